// File: doc/BRIEF.md
# Double-Buffer Circular DMA Channel

This block is one peripheral-to-memory DMA channel that runs in a circular ping-pong arrangement. Software programs two memory base addresses and an item count, then enables the channel. Each peripheral request taken while the channel runs moves one data word to memory. The word goes to the active buffer, at the active base plus a running offset. When the item counter reaches zero, the channel does three things. It switches to the other base address, reloads the counter from the programmed count, and raises a transfer-complete flag.

The channel never stops on its own. It keeps alternating between the two buffers until software clears the enable bit. A consumer reads the buffer-select output to see which half is being filled, and it drains the other half. The completion flag stays set until a bus master writes its bit to the clear register. Pausing a running channel also raises the flag, so that a downstream engine can take the part-filled buffer.

Top module: `dbdma_channel`

## Requirements
- R1: After reset, `ack_o`, `mem_we_o`, `tc_o` and `buf_sel_o` are all 0, and no request is acknowledged until the channel is enabled.
- R2: A request is accepted while the channel is enabled, not paused and has a nonzero programmed count. An accepted request raises `ack_o` and `mem_we_o` in the same cycle, with `mem_wdata_o` equal to `periph_data_i`. The address is the active base plus offset times DATA_W/8. The offset then grows by one.
- R3: After the programmed number of items has been accepted into one buffer, `buf_sel_o` toggles (0 selects the register at offset 1, 1 selects the register at offset 2). The offset also returns to zero, so the next item lands at the other base.
- R4: The item counter reloads on every swap, so every buffer after the first also takes exactly the programmed number of items.
- R5: The channel is never disabled by hardware. It keeps swapping buffers for as long as it receives requests, and it stops accepting requests only after a control write with bit 0 clear.
- R6: `tc_o` is 1 from the cycle after the last item of a buffer is accepted, and it stays 1 until it is cleared.
- R7: A register write to offset 4 with bit 0 set clears `tc_o` on the next cycle, and the same write with bit 0 clear has no effect. A completion event in the same cycle as a clear wins, and `tc_o` stays 1.
- R8: The control register is at offset 0, with bit 0 as enable and bit 1 as pause. Setting pause on an enabled channel raises `tc_o` and stops acknowledgements. Clearing pause resumes at the same buffer and offset.
- R9: A write to the count register (offset 3) while the channel is enabled is ignored. Enabling a disabled channel always restarts at buffer 0, offset 0, with the programmed count.
- R10: A programmed count of zero keeps an enabled channel from acknowledging any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register offset (0 control, 1 base 0, 2 base 1, 3 count, 4 flag clear) |
| reg_wdata | input | ADDR_W | Register write data |
| req_i | input | 1 | Peripheral transfer request |
| periph_data_i | input | DATA_W | Peripheral data word |
| ack_o | output | 1 | Request accepted this cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| buf_sel_o | output | 1 | Buffer currently being filled |
| tc_o | output | 1 | Transfer-complete flag |

## Verification
The bench builds the channel with 16-bit addresses, 16-bit data and a 4-bit counter. At that size a buffer of three items ends within a few cycles, and many buffer swaps fit into a short run. The narrow counter also allows a count of zero and small counts to be reprogrammed between enables. The two-byte word checks that the offset is scaled into a byte address. Chosen cycles put a flag clear against a completion, a pause in the middle of a buffer, and a count write against a running channel.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_BASE0 = 1;
  localparam int unsigned OFS_BASE1 = 2;
  localparam int unsigned OFS_COUNT = 3;
  localparam int unsigned OFS_CLEAR = 4;

  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_HOLD  = 1;
  localparam int unsigned BIT_TCCLR = 0;

  typedef struct packed {
    logic start;      // enable rises
    logic hold_rise;  // pause rises on a running channel
    logic clear;      // flag clear requested
  } ctl_evt_t;
endpackage

// File: rtl/dbdma_regs.sv
module dbdma_regs
  import dbdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RA_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              run_o,
  output logic              hold_o,
  output logic [ADDR_W-1:0] base0_o,
  output logic [ADDR_W-1:0] base1_o,
  output logic [CNT_W-1:0]  count_o,
  output ctl_evt_t          evt_o
);
  logic wr_ctrl, wr_b0, wr_b1, wr_cnt, wr_clr;
  logic run_q, run_d, hold_q, hold_d;
  logic [ADDR_W-1:0] b0_q, b1_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    wr_ctrl = reg_we && (reg_addr == RA_W'(OFS_CTRL));
    wr_b0   = reg_we && (reg_addr == RA_W'(OFS_BASE0));
    wr_b1   = reg_we && (reg_addr == RA_W'(OFS_BASE1));
    wr_cnt  = reg_we && (reg_addr == RA_W'(OFS_COUNT));
    wr_clr  = reg_we && (reg_addr == RA_W'(OFS_CLEAR));
    run_d   = reg_wdata[BIT_RUN];
    hold_d  = reg_wdata[BIT_HOLD];
    cnt_en  = wr_cnt && !run_q;
    cnt_d   = reg_wdata[CNT_W-1:0];
    evt_o.start     = wr_ctrl && run_d && !run_q;
    evt_o.hold_rise = wr_ctrl && run_q && run_d && hold_d && !hold_q;
    evt_o.clear     = wr_clr && reg_wdata[BIT_TCCLR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
      b0_q   <= '0;
      b1_q   <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= run_d;
        hold_q <= hold_d;
      end
      if (wr_b0)  b0_q  <= reg_wdata;
      if (wr_b1)  b1_q  <= reg_wdata;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign run_o   = run_q;
  assign hold_o  = hold_q;
  assign base0_o = b0_q;
  assign base1_o = b1_q;
  assign count_o = cnt_q;

  // R9: programmed count is frozen while the channel runs
  a_r9_count_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(cnt_q));
  // R5: only a control write can stop the channel
  a_r5_no_self_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wr_ctrl) |=> run_q);
endmodule

// File: rtl/dbdma_xfer.sv
module dbdma_xfer #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              hold_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base0_i,
  input  logic [ADDR_W-1:0] base1_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] pdata_i,
  output logic              ack_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              sel_o,
  output logic              done_o
);
  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned SHIFT = (BYTES > 1) ? $clog2(BYTES) : 0;

  logic [CNT_W-1:0] left_q, left_d, off_q, off_d;
  logic sel_q, sel_d;
  logic live, beat, last, upd;
  logic [ADDR_W-1:0] base_act, off_bytes;

  always_comb begin
    live   = run_i && !hold_i && (count_i != '0);
    beat   = live && req_i;
    last   = (left_q == CNT_W'(1));
    left_d = left_q;
    off_d  = off_q;
    sel_d  = sel_q;
    done_o = 1'b0;
    if (start_i) begin
      left_d = count_i;
      off_d  = '0;
      sel_d  = 1'b0;
    end else if (beat) begin
      if (last) begin
        left_d = count_i;
        off_d  = '0;
        sel_d  = !sel_q;
        done_o = 1'b1;
      end else begin
        left_d = left_q - CNT_W'(1);
        off_d  = off_q + CNT_W'(1);
      end
    end
    upd = start_i || beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      off_q  <= '0;
      sel_q  <= 1'b0;
    end else if (upd) begin
      left_q <= left_d;
      off_q  <= off_d;
      sel_q  <= sel_d;
    end
  end

  generate
    if (SHIFT == 0) begin : g_byte_step
      assign off_bytes = ADDR_W'(off_q);
    end else begin : g_word_step
      assign off_bytes = ADDR_W'(off_q) << SHIFT;
    end
  endgenerate

  assign base_act    = sel_q ? base1_i : base0_i;
  assign ack_o       = beat;
  assign mem_we_o    = beat;
  assign mem_addr_o  = base_act + off_bytes;
  assign mem_wdata_o = pdata_i;
  assign sel_o       = sel_q;

  // R3: the last item of a buffer swaps buffers and rewinds the offset
  a_r3_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last && !start_i) |=> (sel_q != $past(sel_q)) && (off_q == '0));
  // R4: the counter reloads from the programmed count on a swap
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last && !start_i) |=> (left_q == $past(count_i)));
  // R2: a mid-buffer item advances the offset by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !last && !start_i) |=> (off_q == $past(off_q) + CNT_W'(1)));
  // R8: a paused channel keeps its position
  a_r8_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !start_i) |=> ($stable(off_q) && $stable(sel_q)));
endmodule

// File: rtl/dbdma_flag.sv
module dbdma_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic hold_rise_i,
  input  logic clear_i,
  output logic flag_o
);
  logic flag_q, flag_d, set;

  always_comb begin
    set    = done_i || hold_rise_i;
    flag_d = flag_q;
    if (set)          flag_d = 1'b1;
    else if (clear_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R6: completion or pause always leaves the flag set
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i || hold_rise_i) |=> flag_q);
  // R7: a lone clear drops the flag
  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !done_i && !hold_rise_i) |=> !flag_q);
endmodule

// File: rtl/dbdma_channel.sv
module dbdma_channel
  import dbdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RA_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              req_i,
  input  logic [DATA_W-1:0] periph_data_i,
  output logic              ack_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              buf_sel_o,
  output logic              tc_o
);
  logic run, hold, done;
  logic [ADDR_W-1:0] base0, base1;
  logic [CNT_W-1:0]  count;
  ctl_evt_t evt;

  dbdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .run_o(run), .hold_o(hold), .base0_o(base0),
    .base1_o(base1), .count_o(count), .evt_o(evt)
  );

  dbdma_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .run_i(run), .hold_i(hold), .start_i(evt.start),
    .base0_i(base0), .base1_i(base1), .count_i(count), .req_i(req_i),
    .pdata_i(periph_data_i), .ack_o(ack_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .sel_o(buf_sel_o),
    .done_o(done)
  );

  dbdma_flag u_flag (
    .clk(clk), .rst_n(rst_n), .done_i(done), .hold_rise_i(evt.hold_rise),
    .clear_i(evt.clear), .flag_o(tc_o)
  );

  // R2/R10: acknowledge only a live request on a running, unpaused channel
  a_r2_ack_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (req_i && run && !hold && (count != '0)));
  // R2: every acknowledge carries a memory write of the peripheral word
  a_r2_write_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (mem_we_o && (mem_wdata_o == periph_data_i)));
endmodule

// File: tb/dbdma_channel_tb.sv
module dbdma_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int BYTES = DW / 8;

  logic clk, rst_n;
  logic reg_we;
  logic [2:0] reg_addr;
  logic [AW-1:0] reg_wdata;
  logic req_i;
  logic [DW-1:0] periph_data_i;
  logic ack_o, mem_we_o, buf_sel_o, tc_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  int m_run = 0, m_hold = 0, m_prog = 0, m_left = 0, m_off = 0, m_sel = 0, m_flag = 0;
  int m_base[2] = '{0, 0};

  dbdma_channel #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .RA_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req_i(req_i), .periph_data_i(periph_data_i),
    .ack_o(ack_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .buf_sel_o(buf_sel_o), .tc_o(tc_o)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input bit rq, input int d, input bit w, input int a,
                      input int wd, input string tag);
    bit beat, tcev, start, hrise, newrun, newhold;
    int e_addr;
    logic [35:0] exp_v, act_v;
    req_i = rq; periph_data_i = DW'(d); reg_we = w; reg_addr = 3'(a); reg_wdata = AW'(wd);
    #1;
    beat   = rst_n && m_run != 0 && m_hold == 0 && m_prog != 0 && rq;
    e_addr = (m_base[m_sel] + m_off * BYTES) & 16'hFFFF;
    exp_v  = {beat, beat, beat ? 16'(e_addr) : 16'h0, beat ? 16'(d) : 16'h0,
              1'(m_flag), 1'(m_sel)};
    act_v  = {ack_o, mem_we_o, mem_we_o ? mem_addr_o : 16'h0,
              mem_we_o ? mem_wdata_o : 16'h0, tc_o, buf_sel_o};
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: ack/we/addr/data/tc/sel actual %h expected %h", tag, act_v, exp_v);
    end
    @(posedge clk);
    if (rst_n) begin
      newrun = w && a == 0 ? wd[0] : 1'(m_run);
      newhold = w && a == 0 ? wd[1] : 1'(m_hold);
      start = w && a == 0 && wd[0] && m_run == 0;
      hrise = w && a == 0 && m_run != 0 && wd[0] && wd[1] && m_hold == 0;
      tcev = 0;
      if (start) begin m_left = m_prog; m_off = 0; m_sel = 0; end
      else if (beat) begin
        if (m_left == 1) begin m_left = m_prog; m_off = 0; m_sel ^= 1; tcev = 1; end
        else begin m_left--; m_off++; end
      end
      if (tcev || hrise) m_flag = 1;
      else if (w && a == 4 && wd[0]) m_flag = 0;
      if (w && a == 1) m_base[0] = wd & 16'hFFFF;
      if (w && a == 2) m_base[1] = wd & 16'hFFFF;
      if (w && a == 3 && m_run == 0) m_prog = wd & 15;
      m_run = newrun; m_hold = newhold;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input int a, input int wd, input string tag);
    step(0, 0, 1, a, wd, tag);
  endtask

  task automatic stream(input int n, input int seed, input string tag);
    for (int i = 0; i < n; i++) step(1, seed + i * 7, 0, 0, 0, tag);
  endtask

  initial begin
    rst_n = 0; req_i = 0; periph_data_i = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    @(negedge clk);
    step(1, 5, 0, 0, 0, "R1");
    step(1, 6, 0, 0, 0, "R1");
    rst_n = 1;
    step(1, 7, 0, 0, 0, "R1");
    idle(1, "R1");
    wr(1, 16'h1000, "R2");
    wr(2, 16'h2000, "R2");
    wr(3, 3, "R2");
    stream(2, 16'h100, "R1");          // not enabled yet: no ack
    wr(0, 1, "R2");
    stream(3, 16'h200, "R2");          // fills buffer 0
    idle(1, "R6");
    stream(4, 16'h300, "R3");          // buffer 1 then into buffer 0
    step(0, 0, 1, 4, 2, "R7");         // clear with bit 0 clear: no effect
    idle(1, "R7");
    step(0, 0, 1, 4, 1, "R7");         // clear
    idle(1, "R7");
    wr(3, 5, "R9");                    // ignored while running
    stream(5, 16'h400, "R4");
    stream(1, 16'h480, "R9");
    wr(4, 1, "R7");
    step(1, 16'h500, 1, 0, 3, "R8");   // pause while requesting
    stream(3, 16'h510, "R8");
    idle(1, "R8");
    wr(4, 1, "R8");
    wr(0, 1, "R8");                    // resume
    stream(3, 16'h520, "R8");
    wr(0, 0, "R5");                    // disable
    stream(2, 16'h600, "R5");
    wr(3, 0, "R10");
    wr(0, 1, "R10");
    stream(3, 16'h700, "R10");
    wr(0, 0, "R9");
    wr(3, 3, "R9");
    wr(4, 1, "R9");
    wr(0, 1, "R9");                    // restart at buffer 0 offset 0
    step(1, 16'h800, 0, 0, 0, "R9");
    step(1, 16'h801, 0, 0, 0, "R7");
    step(1, 16'h802, 1, 4, 1, "R7");   // completion and clear together
    idle(1, "R7");
    stream(14, 16'h900, "R5");         // many swaps without stopping
    idle(2, "R5");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule